// File: doc/BRIEF.md
# DMA Channel Register Block

This block is the software-visible register set of a single DMA channel. A bus slave port reads and writes it in 16-bit or 32-bit accesses. It holds the programmed transfer parameters: the next-descriptor pointer, the start address, the configuration word, the X and Y counts, and the X and Y strides. It also holds the progress registers that the channel engine keeps up to date, the status word and the peripheral map. All of these are presented as parallel outputs to the sibling blocks that fetch descriptors and move data.

The block enforces the access rules that depend on whether the channel is active. Whenever a configuration write arrives, it raises a one-cycle start pulse or stop pulse. The progress registers are refreshed through a load port, and completion or error events arrive as single-cycle set inputs. Address stepping, descriptor reading and data movement happen outside this block.

The bus address is a halfword address, `bus_addr[5:1]`. Bits 5:2 select one of sixteen word slots on a 4-byte stride, and bit 1 selects the upper half for 16-bit accesses. Read data is returned one cycle after the request, qualified by `bus_rvalid`.

Top module: `dmach_regs`

## Requirements
- R1: After reset, every slot reads as zero except the peripheral map, which reads as the parameter PMAP_RESET (default 0x0045). No start or stop pulse is present and the run bit is 0.
- R2: The word slots and their functions are:
  - 32-bit slots: 0 next descriptor, 1 start address, 8 current descriptor, 9 current address.
  - 16-bit slots: 2 config, 4 X count, 5 X stride, 6 Y count, 7 Y stride, 10 status, 11 peripheral map, 12 current X count, 14 current Y count.
  - A 32-bit write replaces a whole 32-bit slot. A 16-bit write (bus_sz32=0) loads `bus_wdata[15:0]` into the half chosen by bus_addr[1] and leaves the other half unchanged.
- R3: While the run bit is 1, writes to the pointer, address, count, stride, peripheral-map and current-count slots are discarded. When run is 0, the same writes take effect.
- R4: A write to the low half of config (slot 2) stores the value at any time, even while running. If bit 0 (enable) of the written value is 1, the run bit is set and `start_o` pulses for exactly one cycle, which is the cycle in which run first reads 1. A 16-bit write to the upper half of config changes nothing and produces no pulse.
- R5: A config write with bit 0 at 0 clears the run bit. If the channel was running, `stop_o` pulses for one cycle, in the same cycle as the run bit reads 0.
- R6: In the status word, bit 0 is DONE, bit 1 is ERROR and bit 3 is RUN. Writing 1 to DONE or ERROR clears that bit, and writing 0 leaves it unchanged. Status writes never change RUN.
- R7: A `set_done` or `set_err` input in the same cycle as a status write that clears the same bit leaves the bit set.
- R8: Bit 6 of the peripheral map is read-only. A write updates only the other 15 bits.
- R9: Slots 3, 13 and 15 are reserved. They read as zero, and writes to them have no effect.
- R10: `upd_en` loads the current-descriptor, current-address, current-X and current-Y slots from the update inputs. It does so regardless of run, and it takes precedence over a bus write to the same slot in the same cycle.
- R11: A 32-bit read returns the whole slot. A 16-bit read returns the half chosen by bus_addr[1], zero-extended. The upper half of a 16-bit register reads as zero, and a 16-bit write to that upper half is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Access request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_sz32 | input | 1 | 1 = 32-bit access, 0 = 16-bit access |
| bus_addr | input | 5 | Halfword address: [5:2] slot, [1] upper half |
| bus_wdata | input | 32 | Write data |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read request |
| bus_rdata | output | 32 | Read data |
| upd_en | input | 1 | Load the progress slots from the update inputs |
| upd_cdesc | input | 32 | New current descriptor pointer |
| upd_caddr | input | 32 | New current address |
| upd_cx | input | 16 | New current X count |
| upd_cy | input | 16 | New current Y count |
| set_done | input | 1 | Set the DONE status bit |
| set_err | input | 1 | Set the ERROR status bit |
| start_o | output | 1 | One-cycle pulse on a config write that enables the channel |
| stop_o | output | 1 | One-cycle pulse when a config write disables a running channel |
| run_o | output | 1 | Run bit |
| cfg_o | output | 16 | Config word |
| ndesc_o | output | 32 | Next descriptor pointer |
| saddr_o | output | 32 | Start address |
| xcnt_o | output | 16 | X count |
| xmod_o | output | 16 | X stride, signed two's complement |
| ycnt_o | output | 16 | Y count |
| ymod_o | output | 16 | Y stride, signed two's complement |
| pmap_o | output | 16 | Peripheral map |

## Verification
Two functions can fall on the same edge:
- a bus write-one-to-clear of a status bit together with the engine setting that same bit;
- a bus write to a progress slot together with the engine's update load.

The bench provokes both by raising `set_done`, `set_err` or `upd_en` in the cycle that carries the bus write. It then reads the slot back and expects the engine's value: the bit stays set and the loaded value wins. A third overlap is also covered. A config write arriving while the channel runs must land, while the parameter writes issued in the same run are dropped.

// File: rtl/dmach_pkg.sv
package dmach_pkg;
  localparam int NSLOT   = 16;
  localparam int SLOT_W  = $clog2(NSLOT);
  localparam int IX_NDP  = 0;
  localparam int IX_SA   = 1;
  localparam int IX_CFG  = 2;
  localparam int IX_XC   = 4;
  localparam int IX_XM   = 5;
  localparam int IX_YC   = 6;
  localparam int IX_YM   = 7;
  localparam int IX_CDP  = 8;
  localparam int IX_CA   = 9;
  localparam int IX_ST   = 10;
  localparam int IX_PM   = 11;
  localparam int IX_CXC  = 12;
  localparam int IX_CYC  = 14;

  localparam int CFG_EN_BIT  = 0;
  localparam int ST_DONE_BIT = 0;
  localparam int ST_ERR_BIT  = 1;
  localparam int ST_RUN_BIT  = 3;
  localparam int PM_TYPE_BIT = 6;

  function automatic bit slot_reserved(int ix);
    return (ix == 3) || (ix == 13) || (ix == 15);
  endfunction

  function automatic int slot_width(int ix);
    return (ix == IX_NDP || ix == IX_SA || ix == IX_CDP || ix == IX_CA) ? 32 : 16;
  endfunction

  function automatic bit slot_has_upd(int ix);
    return (ix == IX_CDP || ix == IX_CA || ix == IX_CXC || ix == IX_CYC);
  endfunction

  // Merge a full-word or half-word write into an old value.
  function automatic logic [31:0] merge_half(logic [31:0] old, logic [31:0] wd,
                                             logic sz32, logic hi);
    if (sz32)    return wd;
    else if (hi) return {wd[15:0], old[15:0]};
    else         return {old[31:16], wd[15:0]};
  endfunction

  // Select the read data for a full-word or half-word access.
  function automatic logic [31:0] pick_half(logic [31:0] w, logic sz32, logic hi);
    if (sz32) return w;
    return {16'h0000, hi ? w[31:16] : w[15:0]};
  endfunction

  // Write-one-to-clear with a same-cycle set that has priority.
  function automatic logic w1c_bit(logic cur, logic clr, logic set);
    return set | (cur & ~clr);
  endfunction
endpackage

// File: rtl/dmach_decode.sv
module dmach_decode
  import dmach_pkg::*;
(
  input  logic              req,
  input  logic              we,
  input  logic [5:1]        addr,
  output logic [NSLOT-1:0]  wr_vec,
  output logic              rd,
  output logic              hi
);
  logic [SLOT_W-1:0] slot;
  assign slot = addr[5:2];
  assign hi   = addr[1];
  assign rd   = req & ~we;

  for (genvar gi = 0; gi < NSLOT; gi++) begin : g_dec
    assign wr_vec[gi] = req & we & (slot == SLOT_W'(gi));
  end
endmodule

// File: rtl/dmach_word.sv
module dmach_word
  import dmach_pkg::*;
#(
  parameter int W       = 32,
  parameter bit HAS_UPD = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr,
  input  logic        sz32,
  input  logic        hi,
  input  logic [31:0] wd,
  input  logic        lock,
  input  logic        upd,
  input  logic [31:0] upd_val,
  output logic [31:0] q
);
  localparam logic [31:0] MASK = (W >= 32) ? 32'hFFFF_FFFF : ((32'h1 << W) - 32'h1);

  logic [31:0] q_r;
  logic        upd_hit;
  logic        upper_16;
  logic        bus_hit;

  assign upd_hit  = HAS_UPD & upd;
  assign upper_16 = (W < 32) & ~sz32 & hi;
  assign bus_hit  = wr & ~lock & ~upper_16;

  always_ff @(posedge clk) begin
    if (!rst_n)       q_r <= '0;
    else if (upd_hit) q_r <= upd_val & MASK;
    else if (bus_hit) q_r <= merge_half(q_r, wd, sz32, hi) & MASK;
  end

  assign q = q_r;

  // R3: a locked slot keeps its value unless the engine loads it
  p_locked_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (lock && !upd_hit) |=> $stable(q_r));
endmodule

// File: rtl/dmach_status.sv
module dmach_status
  import dmach_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_wr,
  input  logic cfg_en,
  input  logic st_wr,
  input  logic clr_done,
  input  logic clr_err,
  input  logic set_done,
  input  logic set_err,
  output logic run,
  output logic done,
  output logic err,
  output logic start_o,
  output logic stop_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run     <= 1'b0;
      done    <= 1'b0;
      err     <= 1'b0;
      start_o <= 1'b0;
      stop_o  <= 1'b0;
    end else begin
      if (cfg_wr) run <= cfg_en;
      start_o <= cfg_wr & cfg_en;
      stop_o  <= cfg_wr & ~cfg_en & run;
      done    <= w1c_bit(done, st_wr & clr_done, set_done);
      err     <= w1c_bit(err,  st_wr & clr_err,  set_err);
    end
  end

  // R4: a start pulse coincides with the run bit set
  p_start_run_r4: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |-> run);
  // R5: a stop pulse coincides with the run bit clear
  p_stop_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    stop_o |-> !run);
  // R7: an engine set is never lost to a same-cycle clear
  p_set_done_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    set_done |=> done);
  p_set_err_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    set_err |=> err);
  // R6: a one written to DONE clears it when no set competes
  p_w1c_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_wr && clr_done && !set_done) |=> !done);
endmodule

// File: rtl/dmach_regs.sv
module dmach_regs
  import dmach_pkg::*;
#(
  parameter logic [15:0] PMAP_RESET = 16'h0045
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_req,
  input  logic        bus_we,
  input  logic        bus_sz32,
  input  logic [5:1]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic        bus_rvalid,
  output logic [31:0] bus_rdata,
  input  logic        upd_en,
  input  logic [31:0] upd_cdesc,
  input  logic [31:0] upd_caddr,
  input  logic [15:0] upd_cx,
  input  logic [15:0] upd_cy,
  input  logic        set_done,
  input  logic        set_err,
  output logic        start_o,
  output logic        stop_o,
  output logic        run_o,
  output logic [15:0] cfg_o,
  output logic [31:0] ndesc_o,
  output logic [31:0] saddr_o,
  output logic [15:0] xcnt_o,
  output logic [15:0] xmod_o,
  output logic [15:0] ycnt_o,
  output logic [15:0] ymod_o,
  output logic [15:0] pmap_o
);
  localparam logic [15:0] PM_RO_MASK = 16'h0001 << PM_TYPE_BIT;

  logic [NSLOT-1:0] wr_vec;
  logic             rd;
  logic             hi;
  logic             run, done, err;
  logic             cfg_wr;
  logic             low_wr;
  logic [15:0]      cfg_q;
  logic [15:0]      pmap_q;
  logic [31:0]      word_q  [NSLOT];
  logic [31:0]      upd_vec [NSLOT];

  dmach_decode u_dec (
    .req(bus_req), .we(bus_we), .addr(bus_addr),
    .wr_vec(wr_vec), .rd(rd), .hi(hi)
  );

  // A write that reaches the low half of a 16-bit slot
  assign low_wr = bus_sz32 | ~hi;
  assign cfg_wr = wr_vec[IX_CFG] & low_wr;

  dmach_status u_st (
    .clk(clk), .rst_n(rst_n),
    .cfg_wr(cfg_wr), .cfg_en(bus_wdata[CFG_EN_BIT]),
    .st_wr(wr_vec[IX_ST] & low_wr),
    .clr_done(bus_wdata[ST_DONE_BIT]), .clr_err(bus_wdata[ST_ERR_BIT]),
    .set_done(set_done), .set_err(set_err),
    .run(run), .done(done), .err(err),
    .start_o(start_o), .stop_o(stop_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      pmap_q <= PMAP_RESET;
    end else begin
      if (cfg_wr) cfg_q <= bus_wdata[15:0];
      if (wr_vec[IX_PM] && low_wr && !run)
        pmap_q <= (pmap_q & PM_RO_MASK) | (bus_wdata[15:0] & ~PM_RO_MASK);
    end
  end

  always_comb begin
    for (int i = 0; i < NSLOT; i++) upd_vec[i] = '0;
    upd_vec[IX_CDP] = upd_cdesc;
    upd_vec[IX_CA]  = upd_caddr;
    upd_vec[IX_CXC] = {16'h0000, upd_cx};
    upd_vec[IX_CYC] = {16'h0000, upd_cy};
  end

  for (genvar gi = 0; gi < NSLOT; gi++) begin : g_slot
    if (gi == IX_CFG) begin : g_cfg
      assign word_q[gi] = {16'h0000, cfg_q};
    end else if (gi == IX_ST) begin : g_st
      logic [15:0] st_w;
      always_comb begin
        st_w = '0;
        st_w[ST_DONE_BIT] = done;
        st_w[ST_ERR_BIT]  = err;
        st_w[ST_RUN_BIT]  = run;
      end
      assign word_q[gi] = {16'h0000, st_w};
    end else if (gi == IX_PM) begin : g_pm
      assign word_q[gi] = {16'h0000, pmap_q};
    end else if (slot_reserved(gi)) begin : g_rsv
      assign word_q[gi] = '0;
    end else begin : g_plain
      dmach_word #(.W(slot_width(gi)), .HAS_UPD(slot_has_upd(gi))) u_w (
        .clk(clk), .rst_n(rst_n), .wr(wr_vec[gi]), .sz32(bus_sz32), .hi(hi),
        .wd(bus_wdata), .lock(run), .upd(upd_en), .upd_val(upd_vec[gi]),
        .q(word_q[gi])
      );
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      bus_rvalid <= rd;
      bus_rdata  <= rd ? pick_half(word_q[bus_addr[5:2]], bus_sz32, hi) : '0;
    end
  end

  assign run_o   = run;
  assign cfg_o   = cfg_q;
  assign pmap_o  = pmap_q;
  assign ndesc_o = word_q[IX_NDP];
  assign saddr_o = word_q[IX_SA];
  assign xcnt_o  = word_q[IX_XC][15:0];
  assign xmod_o  = word_q[IX_XM][15:0];
  assign ycnt_o  = word_q[IX_YC][15:0];
  assign ymod_o  = word_q[IX_YM][15:0];

  // R8: the peripheral-type bit never changes after reset
  p_type_fixed_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $stable(pmap_q[PM_TYPE_BIT]));
  // R4: after a config write the run bit equals the written enable bit
  p_cfg_run_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> (run == cfg_q[CFG_EN_BIT]));
  // R3: the peripheral map is frozen while running
  p_pmap_locked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> $stable(pmap_q));
endmodule

// File: tb/sim_dmach_regs.sv
module sim_dmach_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_req = 1'b0, bus_we = 1'b0, bus_sz32 = 1'b0;
  logic [5:1]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_rvalid;
  logic [31:0] bus_rdata;
  logic        upd_en = 1'b0;
  logic [31:0] upd_cdesc = '0, upd_caddr = '0;
  logic [15:0] upd_cx = '0, upd_cy = '0;
  logic        set_done = 1'b0, set_err = 1'b0;
  logic        start_o, stop_o, run_o;
  logic [15:0] cfg_o, xcnt_o, xmod_o, ycnt_o, ymod_o, pmap_o;
  logic [31:0] ndesc_o, saddr_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;

  dmach_regs u0 (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
    .bus_sz32(bus_sz32), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata), .upd_en(upd_en),
    .upd_cdesc(upd_cdesc), .upd_caddr(upd_caddr), .upd_cx(upd_cx),
    .upd_cy(upd_cy), .set_done(set_done), .set_err(set_err),
    .start_o(start_o), .stop_o(stop_o), .run_o(run_o), .cfg_o(cfg_o),
    .ndesc_o(ndesc_o), .saddr_o(saddr_o), .xcnt_o(xcnt_o), .xmod_o(xmod_o),
    .ycnt_o(ycnt_o), .ymod_o(ymod_o), .pmap_o(pmap_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: pops one expected item per returned read
  always @(negedge clk) begin
    if (rst_n && bus_rvalid) begin
      if (exp_q.size() == 0) check("read without expectation", 32'h1, 32'h0);
      else check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
    end
  end

  // One bus cycle; sideband inputs set by the caller ride in the same cycle
  task automatic bus_op(input logic we, input logic sz, input logic [5:0] a,
                        input logic [31:0] d);
    bus_req = 1'b1; bus_we = we; bus_sz32 = sz; bus_addr = a[5:1]; bus_wdata = d;
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0;
    upd_en = 1'b0; set_done = 1'b0; set_err = 1'b0;
  endtask

  task automatic wr(input logic sz, input logic [5:0] a, input logic [31:0] d);
    bus_op(1'b1, sz, a, d);
  endtask

  task automatic rd(input string tag, input logic sz, input logic [5:0] a,
                    input logic [31:0] exp);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    bus_op(1'b0, sz, a, 32'h0);
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset values
    check("R1 run", {31'b0, run_o}, 32'h0);
    check("R1 start/stop", {30'b0, start_o, stop_o}, 32'h0);
    rd("R1 ndesc", 1, 6'h00, 32'h0);
    rd("R1 pmap", 1, 6'h2C, 32'h0045);
    rd("R1 status", 1, 6'h28, 32'h0);
    // R2 full and half writes to a pointer
    wr(1, 6'h00, 32'h1234_5678);
    rd("R2 full write", 1, 6'h00, 32'h1234_5678);
    wr(0, 6'h02, 32'h0000_ABCD);
    rd("R2 upper half write", 1, 6'h00, 32'hABCD_5678);
    rd("R11 16-bit upper read", 0, 6'h02, 32'h0000_ABCD);
    rd("R11 16-bit lower read", 0, 6'h00, 32'h0000_5678);
    wr(0, 6'h04, 32'h0000_1111);
    rd("R2 lower half write", 1, 6'h04, 32'h0000_1111);
    // R11 16-bit registers
    wr(1, 6'h14, 32'h0001_FFFE);
    rd("R11 upper bits dropped", 1, 6'h14, 32'h0000_FFFE);
    check("R11 signed stride", {16'h0, xmod_o}, 32'h0000_FFFE);
    wr(0, 6'h16, 32'h0000_7777);
    rd("R11 upper half write ignored", 1, 6'h14, 32'h0000_FFFE);
    // R8 read-only type bit
    wr(1, 6'h2C, 32'h0000_0003);
    rd("R8 type bit kept", 1, 6'h2C, 32'h0000_0043);
    // R9 reserved slots
    wr(1, 6'h0C, 32'hFFFF_FFFF);
    rd("R9 reserved 3", 1, 6'h0C, 32'h0);
    rd("R9 reserved 13", 1, 6'h34, 32'h0);
    rd("R9 reserved 15", 0, 6'h3E, 32'h0);
    wr(1, 6'h10, 32'h0000_0020);
    rd("R2 xcount", 1, 6'h10, 32'h0000_0020);
    // R4 upper-half config write does nothing
    wr(0, 6'h0A, 32'h0000_0001);
    check("R4 upper cfg no start", {31'b0, start_o}, 32'h0);
    check("R4 upper cfg no run", {31'b0, run_o}, 32'h0);
    // R4 enable
    wr(0, 6'h08, 32'h0000_0001);
    check("R4 start pulse", {31'b0, start_o}, 32'h1);
    check("R4 run set", {31'b0, run_o}, 32'h1);
    check("R5 no stop", {31'b0, stop_o}, 32'h0);
    rd("R4 status run", 1, 6'h28, 32'h0000_0008);
    check("R4 pulse one cycle", {31'b0, start_o}, 32'h0);
    // R3 locked while running
    wr(1, 6'h10, 32'h0000_0055);
    rd("R3 xcount locked", 1, 6'h10, 32'h0000_0020);
    wr(1, 6'h00, 32'h0);
    rd("R3 ndesc locked", 1, 6'h00, 32'hABCD_5678);
    wr(1, 6'h2C, 32'h0);
    rd("R3 pmap locked", 1, 6'h2C, 32'h0000_0043);
    wr(1, 6'h30, 32'h0000_0009);
    rd("R3 cur x locked", 1, 6'h30, 32'h0);
    wr(0, 6'h08, 32'h0000_0003);
    check("R4 restart pulse", {31'b0, start_o}, 32'h1);
    rd("R4 cfg written while running", 1, 6'h08, 32'h0000_0003);
    // R10 update port
    upd_en = 1'b1; upd_cdesc = 32'hDEAD_0000; upd_caddr = 32'h0000_0100;
    upd_cx = 16'd7; upd_cy = 16'd2;
    rd("R10 status during load", 1, 6'h28, 32'h0000_0008);
    rd("R10 cur x", 1, 6'h30, 32'h0000_0007);
    rd("R10 cur addr", 1, 6'h24, 32'h0000_0100);
    rd("R10 cur y", 0, 6'h38, 32'h0000_0002);
    rd("R10 cur desc", 1, 6'h20, 32'hDEAD_0000);
    // R6 write-one-to-clear
    set_done = 1'b1;
    rd("R6 status before set", 1, 6'h28, 32'h0000_0008);
    rd("R6 done set", 1, 6'h28, 32'h0000_0009);
    wr(1, 6'h28, 32'h0);
    rd("R6 zero keeps", 1, 6'h28, 32'h0000_0009);
    wr(1, 6'h28, 32'h0000_0008);
    rd("R6 run not writable", 1, 6'h28, 32'h0000_0009);
    wr(1, 6'h28, 32'h0000_0001);
    rd("R6 done cleared", 1, 6'h28, 32'h0000_0008);
    // R7 set against clear in the same cycle
    set_err = 1'b1;
    wr(1, 6'h28, 32'h0000_0002);
    rd("R7 err set wins", 1, 6'h28, 32'h0000_000A);
    set_done = 1'b1;
    wr(1, 6'h28, 32'h0000_0003);
    rd("R7 done wins err clears", 1, 6'h28, 32'h0000_0009);
    wr(1, 6'h28, 32'h0000_0003);
    rd("R6 both cleared", 1, 6'h28, 32'h0000_0008);
    // R5 disable
    wr(0, 6'h08, 32'h0000_0000);
    check("R5 stop pulse", {31'b0, stop_o}, 32'h1);
    check("R5 run cleared", {31'b0, run_o}, 32'h0);
    check("R5 no start", {31'b0, start_o}, 32'h0);
    rd("R5 status idle", 1, 6'h28, 32'h0);
    check("R5 pulse one cycle", {31'b0, stop_o}, 32'h0);
    // R3 unlocked again
    wr(1, 6'h10, 32'h0000_0055);
    rd("R3 write after stop", 1, 6'h10, 32'h0000_0055);
    check("R3 xcnt port", {16'h0, xcnt_o}, 32'h0000_0055);
    // R10 update beats a same-cycle bus write
    upd_en = 1'b1; upd_caddr = 32'h0000_0200;
    wr(1, 6'h24, 32'h0000_0300);
    rd("R10 load wins", 1, 6'h24, 32'h0000_0200);
    wr(1, 6'h24, 32'h0000_0300);
    rd("R10 bus write alone", 1, 6'h24, 32'h0000_0300);
    // R5 disable while idle gives no stop pulse
    wr(0, 6'h08, 32'h0000_0000);
    check("R5 idle no stop", {31'b0, stop_o}, 32'h0);
    repeat (3) @(negedge clk);
    check("queue drained", exp_q.size(), 32'h0);
    finish_run();
  end
endmodule